// File: doc/BRIEF.md
# I2C Controller Address-Phase Sequencer

This block opens a transfer on an I2C bus. Software programs a target address (7-bit or 10-bit), a direction, a byte count and a header-only option for 10-bit reads, then raises a start request. The sequencer waits until the bus has been idle long enough, or issues a repeated START if it already holds the bus. It then clocks out one, two or three address bytes, samples the acknowledge bit after each, and drops the start request once the address phase ends.

If another controller wins arbitration, or another controller addresses this device while the request is still waiting, the sequencer stops driving the bus and reports target mode. The data phase and the STOP timing reuse the same two timing counts. SCL and SDA are open-drain: an `_oe` output of 1 pulls the line low. No stream data crosses this block, so every pin is a plain level or a one-cycle strobe, and no valid/ready handshake is used.

Top module: `i2c_addr_seq`

## Requirements
- R1: Configuration fields are captured on `cfg_wr` only while `start_req` is low. A write made while the request is pending has no effect on the address bytes or on `xfer_read`/`xfer_nbytes`.
- R2: `start_set` raises `start_req` and clears `addr_ack`, `addr_nack`, `arb_lost` and `target_mode`. A `start_set` while the request is already pending is ignored.
- R3: A START from the idle bus is driven only after `bus_busy` has been low for `low_cnt`+1 consecutive clocks. With `bus_busy` high, SDA and SCL stay released.
- R4: A START pulls SDA low while SCL is released. SCL is pulled low `high_cnt`+1 clocks later.
- R5: Address bits go out MSB first, one per SCL pulse, with SDA released for a ninth pulse on which ACK (SDA low) is sampled. In 7-bit mode the only byte is `{addr[6:0], read}`.
- R6: A 10-bit write sends the header `{5'b11110, addr[9:8], 0}` and then `addr[7:0]`.
- R7: A 10-bit read without the header-only flag sends the header with bit 0 = 0, then `addr[7:0]`, then a repeated START, then the header with bit 0 = 1.
- R8: A 10-bit read with the header-only flag, started while the bus is held, issues a repeated START and sends only the header with bit 0 = 1.
- R9: After the last address byte is acknowledged, `addr_ack` is set and `start_req` clears. At the first NACK, `addr_nack` is set, `start_req` clears and no further byte is sent. In both cases `own_bus` stays high with SCL held low.
- R10: If SDA reads low on an SCL high phase while the sequencer releases it for an address bit, `arb_lost` and `target_mode` are set, `start_req` and `own_bus` clear, and both lines are released.
- R11: If `tgt_match` arrives while the request waits for the bus, `target_mode` is set, no START is issued, and `start_req` stays high until a `match_clr` pulse clears it.
- R12: `release_bus` while holding the bus produces a STOP: SDA rises while SCL is released, after which `own_bus` clears.
- R13: `xfer_read` and `xfer_nbytes` present the captured direction and byte count unchanged. A count of 0xFF stands for 255 or more bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Strobe that captures the cfg_* fields |
| cfg_ten_bit | input | 1 | 1 selects 10-bit addressing |
| cfg_addr | input | 10 | Target address |
| cfg_read | input | 1 | 1 selects read direction |
| cfg_hdr_only | input | 1 | 10-bit read: send only the read header after repeated START |
| cfg_nbytes | input | NBW | Byte count for the following data phase |
| low_cnt | input | TW | SCL low count; also bus-free and repeated-start setup time |
| high_cnt | input | TW | SCL high count; also START hold and STOP setup time |
| start_set | input | 1 | Raises the start request |
| bus_busy | input | 1 | Bus monitor reports a transfer in progress |
| tgt_match | input | 1 | Target logic has matched this device's own address |
| match_clr | input | 1 | Target logic clears its match flag |
| release_bus | input | 1 | Issue STOP while holding the bus |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| start_req | output | 1 | Start request pending |
| own_bus | output | 1 | Sequencer holds the bus |
| target_mode | output | 1 | Reverted to target role |
| addr_ack | output | 1 | Address phase ended with ACK |
| addr_nack | output | 1 | Address phase ended with NACK |
| arb_lost | output | 1 | Arbitration lost during address |
| xfer_read | output | 1 | Captured direction |
| xfer_nbytes | output | NBW | Captured byte count |

## Verification
The bench measures the exact clock of the START edge after the bus goes idle. A sequencer that ignored `bus_busy`, or counted the wrong interval, would move that edge. An on-bus target model decodes every byte, START and STOP. This catches swapped header bits, a missing repeated START between the two halves of a 10-bit read, and a header-only read that still resends the full address. A NACK on the first 10-bit byte must stop the phase, so a design that sends the second byte anyway shows an extra byte. The bench forces SDA low against a released address bit and holds a target match while the bus frees. A design that kept driving, or later issued a START, shows up on `sda_oe` and `scl_oe`.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [3:0] {
    T_IDLE, T_FREE, T_STHOLD, T_BYTE, T_RS_LOW, T_RS_HIGH,
    T_HOLD, T_STOP_LOW, T_STOP_HIGH
  } seq_state_e;

  typedef enum logic [1:0] {B_IDLE, B_LOW, B_WAITHI, B_HIGH} bit_state_e;

  // step 0: 7-bit byte or 10-bit header (write), step 1: low address, step 2: header (read)
  function automatic logic [7:0] addr_byte(input logic ten, input logic [9:0] a,
                                           input logic rd, input logic [1:0] step);
    if (!ten) return {a[6:0], rd};
    case (step)
      2'd1:    return a[7:0];
      2'd2:    return {5'b11110, a[9:8], 1'b1};
      default: return {5'b11110, a[9:8], 1'b0};
    endcase
  endfunction

  function automatic logic [1:0] first_step(input logic ten, input logic rd, input logic hdr);
    return (ten && rd && hdr) ? 2'd2 : 2'd0;
  endfunction

  function automatic logic [1:0] last_step(input logic ten, input logic rd);
    if (!ten) return 2'd0;
    return rd ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/i2c_seq_timer.sv
module i2c_seq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/i2c_seq_shifter.sv
module i2c_seq_shifter import i2c_seq_pkg::*; #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [7:0]    byte_in,
  input  logic [TW-1:0] low_cnt,
  input  logic [TW-1:0] high_cnt,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_low,
  output logic          sda_low,
  output logic          done,
  output logic          ack,
  output logic          arb_loss
);
  bit_state_e    st;
  logic [7:0]    sh;
  logic [3:0]    bidx;
  logic          tload, texp;
  logic [TW-1:0] tval;

  assign arb_loss = (st == B_WAITHI) && scl_in && (bidx != 4'd8) && !sda_low && !sda_in;
  assign done     = (st == B_HIGH) && texp && (bidx == 4'd8);
  assign tval     = (st == B_WAITHI) ? high_cnt : low_cnt;
  assign tload    = go || ((st == B_WAITHI) && scl_in) ||
                    ((st == B_HIGH) && texp && (bidx != 4'd8));

  i2c_seq_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tload), .val(tval), .expired(texp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= B_IDLE; sh <= '0; bidx <= '0;
      scl_low <= 1'b0; sda_low <= 1'b0; ack <= 1'b0;
    end else if (go) begin
      st <= B_LOW; sh <= byte_in; bidx <= '0;
      scl_low <= 1'b1; sda_low <= ~byte_in[7];
    end else begin
      case (st)
        B_LOW: if (texp) begin
          st <= B_WAITHI; scl_low <= 1'b0;
        end
        B_WAITHI: if (scl_in) begin
          if (arb_loss) begin
            st <= B_IDLE; sda_low <= 1'b0; scl_low <= 1'b0;
          end else begin
            if (bidx == 4'd8) ack <= !sda_in;
            st <= B_HIGH;
          end
        end
        B_HIGH: if (texp) begin
          if (bidx == 4'd8) st <= B_IDLE;
          else begin
            st <= B_LOW; scl_low <= 1'b1;
            sda_low <= (bidx == 4'd7) ? 1'b0 : ~sh[6];
            sh <= {sh[6:0], 1'b0};
            bidx <= bidx + 4'd1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq import i2c_seq_pkg::*; #(
  parameter int TW  = 8,
  parameter int NBW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic           cfg_ten_bit,
  input  logic [9:0]     cfg_addr,
  input  logic           cfg_read,
  input  logic           cfg_hdr_only,
  input  logic [NBW-1:0] cfg_nbytes,
  input  logic [TW-1:0]  low_cnt,
  input  logic [TW-1:0]  high_cnt,
  input  logic           start_set,
  input  logic           bus_busy,
  input  logic           tgt_match,
  input  logic           match_clr,
  input  logic           release_bus,
  input  logic           scl_in,
  input  logic           sda_in,
  output logic           scl_oe,
  output logic           sda_oe,
  output logic           start_req,
  output logic           own_bus,
  output logic           target_mode,
  output logic           addr_ack,
  output logic           addr_nack,
  output logic           arb_lost,
  output logic           xfer_read,
  output logic [NBW-1:0] xfer_nbytes
);
  logic           ten_q, rd_q, hdr_q, match_pend;
  logic [9:0]     addr_q;
  logic [NBW-1:0] nb_q;
  seq_state_e     st, nxt;
  logic [1:0]     step, step_nxt, go_step, first_s, last_s;
  logic           tload, texp;
  logic [TW-1:0]  tval;
  logic           sh_go, sh_scl, sh_sda, sh_done, sh_ack, sh_arb;
  logic [7:0]     sh_byte;
  logic           tgt_hit;

  assign first_s     = first_step(ten_q, rd_q, hdr_q);
  assign last_s      = last_step(ten_q, rd_q);
  assign sh_byte     = addr_byte(ten_q, addr_q, rd_q, go_step);
  assign tgt_hit     = ((st == T_IDLE) || (st == T_FREE)) && start_req && !target_mode && tgt_match;
  assign xfer_read   = rd_q;
  assign xfer_nbytes = nb_q;

  i2c_seq_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tload), .val(tval), .expired(texp)
  );

  i2c_seq_shifter #(.TW(TW)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(sh_go), .byte_in(sh_byte),
    .low_cnt(low_cnt), .high_cnt(high_cnt), .scl_in(scl_in), .sda_in(sda_in),
    .scl_low(sh_scl), .sda_low(sh_sda), .done(sh_done), .ack(sh_ack), .arb_loss(sh_arb)
  );

  always_comb begin
    nxt = st; tload = 1'b0; tval = low_cnt; sh_go = 1'b0;
    go_step = step; step_nxt = step;
    case (st)
      T_IDLE: if (start_req && !target_mode && !tgt_match) begin
        nxt = T_FREE; tload = 1'b1; step_nxt = first_s;
      end
      T_FREE: begin
        if (tgt_hit) nxt = T_IDLE;
        else if (bus_busy) tload = 1'b1;
        else if (texp) begin nxt = T_STHOLD; tload = 1'b1; tval = high_cnt; end
      end
      T_STHOLD: if (texp) begin nxt = T_BYTE; sh_go = 1'b1; end
      T_BYTE: begin
        if (sh_arb) nxt = T_IDLE;
        else if (sh_done) begin
          if (!sh_ack || step == last_s) nxt = T_HOLD;
          else if (step == 2'd1 && last_s == 2'd2) begin
            nxt = T_RS_LOW; tload = 1'b1; step_nxt = 2'd2;
          end else begin
            sh_go = 1'b1; go_step = step + 2'd1; step_nxt = step + 2'd1;
          end
        end
      end
      T_HOLD: begin
        if (start_req) begin nxt = T_RS_LOW; tload = 1'b1; step_nxt = first_s; end
        else if (release_bus) begin nxt = T_STOP_LOW; tload = 1'b1; end
      end
      T_RS_LOW:    if (texp) begin nxt = T_RS_HIGH; tload = 1'b1; end
      T_RS_HIGH:   if (texp) begin nxt = T_STHOLD; tload = 1'b1; tval = high_cnt; end
      T_STOP_LOW:  if (texp) begin nxt = T_STOP_HIGH; tload = 1'b1; tval = high_cnt; end
      T_STOP_HIGH: if (texp) nxt = T_IDLE;
      default: nxt = T_IDLE;
    endcase
  end

  always_comb begin
    case (st)
      T_STHOLD:    begin scl_oe = 1'b0;   sda_oe = 1'b1;   end
      T_BYTE:      begin scl_oe = sh_scl; sda_oe = sh_sda; end
      T_RS_LOW,
      T_HOLD:      begin scl_oe = 1'b1;   sda_oe = 1'b0;   end
      T_STOP_LOW:  begin scl_oe = 1'b1;   sda_oe = 1'b1;   end
      T_STOP_HIGH: begin scl_oe = 1'b0;   sda_oe = 1'b1;   end
      default:     begin scl_oe = 1'b0;   sda_oe = 1'b0;   end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= T_IDLE; step <= '0;
      ten_q <= 1'b0; rd_q <= 1'b0; hdr_q <= 1'b0; addr_q <= '0; nb_q <= '0;
      start_req <= 1'b0; own_bus <= 1'b0; target_mode <= 1'b0; match_pend <= 1'b0;
      addr_ack <= 1'b0; addr_nack <= 1'b0; arb_lost <= 1'b0;
    end else begin
      st <= nxt; step <= step_nxt;
      if (cfg_wr && !start_req) begin
        ten_q <= cfg_ten_bit; rd_q <= cfg_read; hdr_q <= cfg_hdr_only;
        addr_q <= cfg_addr; nb_q <= cfg_nbytes;
      end
      if (start_set && !start_req) begin
        start_req <= 1'b1; addr_ack <= 1'b0; addr_nack <= 1'b0; arb_lost <= 1'b0;
        target_mode <= 1'b0; match_pend <= 1'b0;
      end
      if (tgt_hit) begin target_mode <= 1'b1; match_pend <= 1'b1; end
      if (match_pend && match_clr) begin start_req <= 1'b0; match_pend <= 1'b0; end
      if (st == T_FREE && nxt == T_STHOLD) own_bus <= 1'b1;
      if (st == T_BYTE && sh_arb) begin
        arb_lost <= 1'b1; target_mode <= 1'b1; start_req <= 1'b0; own_bus <= 1'b0;
      end
      if (st == T_BYTE && sh_done && !sh_ack) begin addr_nack <= 1'b1; start_req <= 1'b0; end
      if (st == T_BYTE && sh_done && sh_ack && step == last_s) begin
        addr_ack <= 1'b1; start_req <= 1'b0;
      end
      if (st == T_STOP_HIGH && texp) own_bus <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_addr_seq_chk.sv
module i2c_addr_seq_chk #(
  parameter int TW  = 8,
  parameter int NBW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [TW-1:0]  low_cnt,
  input logic           bus_busy,
  input logic           scl_oe,
  input logic           sda_oe,
  input logic           start_req,
  input logic           own_bus,
  input logic           target_mode,
  input logic           addr_ack,
  input logic           addr_nack,
  input logic           arb_lost,
  input logic           xfer_read,
  input logic [NBW-1:0] xfer_nbytes
);
  logic [15:0] idle_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 idle_run <= '0;
    else if (bus_busy)          idle_run <= '0;
    else if (idle_run != '1)    idle_run <= idle_run + 16'd1;
  end

  p_cfg_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && $past(start_req)) |-> ($stable(xfer_read) && $stable(xfer_nbytes)));

  p_start_after_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && !scl_oe && !$past(own_bus)) |->
      ($past(idle_run) >= 16'(low_cnt) && !$past(bus_busy)));

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_ack, addr_nack, arb_lost}));

  p_done_holds_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(addr_ack) || $rose(addr_nack)) |-> (!start_req && own_bus && scl_oe));

  p_arb_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> (!sda_oe && !scl_oe && !start_req && target_mode && !own_bus));

  p_target_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (target_mode && !own_bus) |-> (!sda_oe && !scl_oe));

  p_stop_released_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(own_bus) |-> (!sda_oe && !scl_oe));
endmodule

bind i2c_addr_seq i2c_addr_seq_chk #(.TW(TW), .NBW(NBW)) u_chk (
  .clk(clk), .rst_n(rst_n), .low_cnt(low_cnt), .bus_busy(bus_busy),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .start_req(start_req), .own_bus(own_bus),
  .target_mode(target_mode), .addr_ack(addr_ack), .addr_nack(addr_nack),
  .arb_lost(arb_lost), .xfer_read(xfer_read), .xfer_nbytes(xfer_nbytes)
);

// File: tb/tb_i2c_addr_seq.sv
module tb_i2c_addr_seq;
  localparam int TW = 8, NBW = 8;
  localparam int LOWC = 4, HIGHC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, cfg_ten_bit = 0, cfg_read = 0, cfg_hdr_only = 0;
  logic [9:0] cfg_addr = '0;
  logic [NBW-1:0] cfg_nbytes = '0;
  logic [TW-1:0] low_cnt = TW'(LOWC), high_cnt = TW'(HIGHC);
  logic start_set = 0, tgt_match = 0, match_clr = 0, release_bus = 0;
  logic ext_busy = 0, force_sda_low = 0;
  logic scl_oe, sda_oe, start_req, own_bus, target_mode, addr_ack, addr_nack, arb_lost, xfer_read;
  logic [NBW-1:0] xfer_nbytes;
  logic scl_line, sda_line, bus_busy;

  logic mon_busy = 0, tgt_sda_low = 0, p_scl = 1, p_sda = 1;
  int bitcnt = 0, nrx = 0, starts = 0, stops = 0, nack_idx = -1;
  logic [7:0] shreg = '0;
  logic [7:0] rx [32];
  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign scl_line = !scl_oe;
  assign sda_line = !sda_oe && !tgt_sda_low && !force_sda_low;
  assign bus_busy = mon_busy | ext_busy;

  i2c_addr_seq #(.TW(TW), .NBW(NBW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ten_bit(cfg_ten_bit),
    .cfg_addr(cfg_addr), .cfg_read(cfg_read), .cfg_hdr_only(cfg_hdr_only),
    .cfg_nbytes(cfg_nbytes), .low_cnt(low_cnt), .high_cnt(high_cnt),
    .start_set(start_set), .bus_busy(bus_busy), .tgt_match(tgt_match),
    .match_clr(match_clr), .release_bus(release_bus), .scl_in(scl_line),
    .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe), .start_req(start_req),
    .own_bus(own_bus), .target_mode(target_mode), .addr_ack(addr_ack),
    .addr_nack(addr_nack), .arb_lost(arb_lost), .xfer_read(xfer_read),
    .xfer_nbytes(xfer_nbytes)
  );

  // bus target model: decodes START/STOP/bytes and acknowledges
  always @(negedge clk) begin
    if (!rst_n) begin
      mon_busy = 0; tgt_sda_low = 0; bitcnt = 0;
    end else begin
      if (p_scl && scl_line && p_sda && !sda_line) begin
        starts++; bitcnt = 0; mon_busy = 1; tgt_sda_low = 0;
      end else if (p_scl && scl_line && !p_sda && sda_line) begin
        stops++; bitcnt = 0; mon_busy = 0; tgt_sda_low = 0;
      end else if (!p_scl && scl_line) begin
        if (bitcnt < 8) begin shreg = {shreg[6:0], sda_line}; bitcnt++; end
        else if (bitcnt == 8) bitcnt = 9;
      end else if (p_scl && !scl_line) begin
        if (bitcnt == 8) begin
          rx[nrx % 32] = shreg;
          tgt_sda_low = (nrx != nack_idx);
          nrx++;
        end else if (bitcnt == 9) begin
          tgt_sda_low = 0; bitcnt = 0;
        end
      end
    end
    p_scl = scl_line; p_sda = sda_line;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic ten, input logic [9:0] a, input logic rd,
                         input logic hdr, input logic [7:0] nb);
    @(negedge clk);
    cfg_ten_bit = ten; cfg_addr = a; cfg_read = rd; cfg_hdr_only = hdr; cfg_nbytes = nb;
    cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_set = 1;
    @(negedge clk); start_set = 0;
  endtask

  task automatic wait_done(input string tag);
    int k = 0;
    while (start_req && k < 3000) begin @(negedge clk); k++; end
    chk(!start_req, {tag, " request completes"}, start_req, 0);
    cyc(2);
  endtask

  task automatic do_stop(input string tag);
    int s0 = stops;
    int k = 0;
    @(negedge clk); release_bus = 1;
    @(negedge clk); release_bus = 0;
    while (own_bus && k < 200) begin @(negedge clk); k++; end
    cyc(2);
    chk(stops == s0 + 1, {tag, " R12 STOP seen"}, stops - s0, 1);
    chk(!own_bus && !scl_oe && !sda_oe, {tag, " R12 lines released"}, {own_bus, scl_oe, sda_oe}, 0);
  endtask

  task automatic t_reset();
    chk(!start_req && !scl_oe && !sda_oe && !own_bus && !target_mode,
        "R2 reset state", {start_req, scl_oe, sda_oe, own_bus, target_mode}, 0);
  endtask

  task automatic t_seven_bit();
    int b0 = nrx;
    int k = 0;
    ext_busy = 1;
    set_cfg(1'b0, 10'h050, 1'b0, 1'b0, 8'hFF);
    pulse_start();
    cyc(20);
    chk(!sda_oe && !scl_oe, "R3 no START while busy", {sda_oe, scl_oe}, 0);
    set_cfg(1'b0, 10'h033, 1'b1, 1'b0, 8'h05);   // ignored: request pending (R1)
    pulse_start();                                 // ignored: already pending (R2)
    chk(xfer_read == 1'b0 && xfer_nbytes == 8'hFF, "R1 pending write ignored",
        {xfer_read, xfer_nbytes}, 9'h0FF);
    @(negedge clk); ext_busy = 0;
    while (!sda_oe && k < 50) begin @(negedge clk); k++; end
    chk(k == LOWC + 1, "R3 START after bus-free count", k, LOWC + 1);
    chk(!scl_oe, "R4 START with SCL released", scl_oe, 0);
    k = 0;
    while (!scl_oe && k < 50) begin @(negedge clk); k++; end
    chk(k == HIGHC + 1, "R4 START hold count", k, HIGHC + 1);
    wait_done("R5");
    chk(nrx - b0 == 1, "R5 one byte in 7-bit mode", nrx - b0, 1);
    chk(rx[b0 % 32] == 8'hA0, "R5 7-bit address byte", rx[b0 % 32], 8'hA0);
    chk(addr_ack && !addr_nack && own_bus && scl_oe, "R9 ack holds bus",
        {addr_ack, addr_nack, own_bus, scl_oe}, 4'b1011);
    chk(xfer_nbytes == 8'hFF && !xfer_read, "R13 count and direction",
        {xfer_read, xfer_nbytes}, 9'h0FF);
    do_stop("7bit");
  endtask

  task automatic t_nack();
    int b0 = nrx;
    nack_idx = nrx;
    set_cfg(1'b1, 10'h2A5, 1'b0, 1'b0, 8'd3);
    pulse_start();
    wait_done("R9 nack");
    nack_idx = -1;
    chk(addr_nack && !addr_ack && own_bus, "R9 nack ends phase", {addr_nack, addr_ack, own_bus}, 3'b101);
    chk(nrx - b0 == 1, "R9 no byte after nack", nrx - b0, 1);
    chk(rx[b0 % 32] == 8'hF4, "R6 header write byte", rx[b0 % 32], 8'hF4);
    do_stop("nack");
  endtask

  task automatic t_ten_write();
    int b0 = nrx;
    int s0 = starts;
    set_cfg(1'b1, 10'h2A5, 1'b0, 1'b0, 8'd3);
    pulse_start();
    cyc(1);
    chk(!addr_nack && start_req, "R2 flags cleared on start", {addr_nack, start_req}, 1);
    wait_done("R6");
    chk(nrx - b0 == 2 && starts - s0 == 1, "R6 two bytes one START", (nrx - b0) * 16 + starts - s0, 8'h21);
    chk(rx[b0 % 32] == 8'hF4 && rx[(b0 + 1) % 32] == 8'hA5, "R6 10-bit write bytes",
        {rx[b0 % 32], rx[(b0 + 1) % 32]}, 16'hF4A5);
    do_stop("10w");
  endtask

  task automatic t_ten_read_full();
    int b0 = nrx;
    int s0 = starts;
    set_cfg(1'b1, 10'h2A5, 1'b1, 1'b0, 8'd1);
    pulse_start();
    wait_done("R7");
    chk(nrx - b0 == 3, "R7 three bytes", nrx - b0, 3);
    chk(starts - s0 == 2, "R7 repeated START", starts - s0, 2);
    chk({rx[b0 % 32], rx[(b0 + 1) % 32], rx[(b0 + 2) % 32]} == 24'hF4A5F5, "R7 byte sequence",
        {rx[b0 % 32], rx[(b0 + 1) % 32], rx[(b0 + 2) % 32]}, 24'hF4A5F5);
    chk(xfer_read && addr_ack && own_bus, "R13 read direction", {xfer_read, addr_ack, own_bus}, 3'b111);
  endtask

  task automatic t_ten_read_hdr();
    int b0 = nrx;
    int s0 = starts;
    int t0 = stops;
    set_cfg(1'b1, 10'h2A5, 1'b1, 1'b1, 8'd2);
    pulse_start();
    wait_done("R8");
    chk(nrx - b0 == 1 && rx[b0 % 32] == 8'hF5, "R8 header-only byte", rx[b0 % 32], 8'hF5);
    chk(starts - s0 == 1 && stops == t0, "R8 repeated START without STOP",
        (starts - s0) * 16 + stops - t0, 8'h10);
    do_stop("hdr");
  endtask

  task automatic t_arb();
    int k = 0;
    set_cfg(1'b0, 10'h050, 1'b0, 1'b0, 8'd1);
    pulse_start();
    while (!sda_oe && k < 100) begin @(negedge clk); k++; end
    force_sda_low = 1;
    wait_done("R10");
    chk(arb_lost && target_mode && !own_bus, "R10 arbitration flags",
        {arb_lost, target_mode, own_bus}, 3'b110);
    chk(!sda_oe && !scl_oe && !addr_ack, "R10 lines released", {sda_oe, scl_oe, addr_ack}, 0);
    force_sda_low = 0;
    cyc(3);
    chk(!mon_busy, "R10 bus returns idle", mon_busy, 0);
  endtask

  task automatic t_target();
    ext_busy = 1;
    set_cfg(1'b0, 10'h050, 1'b0, 1'b0, 8'd1);
    pulse_start();
    cyc(3);
    chk(!target_mode, "R2 target mode cleared by start", target_mode, 0);
    @(negedge clk); tgt_match = 1;
    @(negedge clk); tgt_match = 0;
    cyc(2);
    chk(target_mode && start_req, "R11 target mode, request held", {target_mode, start_req}, 3);
    ext_busy = 0;
    cyc(20);
    chk(!sda_oe && !scl_oe, "R11 no START in target mode", {sda_oe, scl_oe}, 0);
    @(negedge clk); match_clr = 1;
    @(negedge clk); match_clr = 0;
    cyc(1);
    chk(!start_req, "R11 request cleared with match flag", start_req, 0);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
          failures++;
          $display("FAIL watchdog expired");
          $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
          $finish;
        end
      end
    join_none
    cyc(3);
    rst_n = 1;
    cyc(2);
    t_reset();
    t_seven_bit();
    t_nack();
    t_ten_write();
    t_ten_read_full();
    t_ten_read_hdr();
    t_arb();
    t_target();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule